// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a three-wire stereo audio link (bit clock, frame clock, serial data) and turns it into parallel samples. It runs on a fast system clock and samples the bit clock and frame clock as ordinary inputs. Both clocks must toggle much more slowly than the system clock. Words arrive two's complement, MSB first, and each frame carries the left channel before the right one.

Four framings are understood: right-justified with a fixed start offset, I2S, left-justified, and a DSP framing where a one-bit frame pulse marks each channel. Each finished word is placed on a 24-bit channel output together with a one-cycle valid strobe. The framing and the word length come from configuration fields. When the framing field is zero, two mode pins choose the framing instead.

Top module: `serial_audio_rx`

## Requirements
- R1: The effective format is `cfg_fmt` when it is nonzero and `pin_fmt` when `cfg_fmt` is 00. The format codes are 00 right-justified, 01 I2S, 10 left-justified and 11 DSP.
- R2: In right-justified mode with 24-bit words (`cfg_wlen` 00), a frame clock high selects the left channel and low selects the right channel. The bits are taken from the bit at index 8 onward, where index 0 is the first rising bit-clock edge after a frame-clock transition.
- R3: In right-justified mode, `cfg_wlen` 01 gives 20-bit words starting at index 12, and `cfg_wlen` 10 gives 16-bit words starting at index 16. Both are sign-extended to 24 bits. `cfg_wlen` 11 behaves as 24 bits.
- R4: In I2S mode, a frame clock low selects the left channel. The MSB is the bit at index 1, sampled on the rising bit-clock edge.
- R5: In left-justified mode, a frame clock high selects the left channel. The MSB is the bit at index 0, sampled on the rising bit-clock edge.
- R6: In DSP mode, data is sampled on the falling bit-clock edge. The first sample with the frame clock low after a sample with it high is the MSB of a word. These words alternate left, right, starting with left after reset. Left and right strobes never fire together.
- R7: In every mode other than right-justified, bits past the 24th of a word are ignored.
- R8: In every mode other than right-justified, a word shorter than 24 bits is left-aligned, with zeros in the low bits.
- R9: After reset both outputs are zero with valid low. Each word gives exactly one valid pulse of one cycle, and a data output changes only together with its valid pulse.
- R10: The right-justified start offsets stay the same when a channel half is longer than 32 bit clocks. Bits after the word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, oversampled |
| fclk_in | input | 1 | Left/right frame clock, oversampled |
| sdata_in | input | 1 | Serial data |
| cfg_fmt | input | 2 | Format field from the control register; 00 defers to pins |
| cfg_wlen | input | 2 | Right-justified word length: 00/11 = 24, 01 = 20, 10 = 16 |
| pin_fmt | input | 2 | External format pins |
| left_data | output | 24 | Last left sample |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
The properties assume that the configuration inputs stay constant while the block is out of reset. They also assume that every bit-clock phase lasts several system cycles. The stimulus meets the first assumption by pulsing reset around every configuration change. It meets the second by holding each bit-clock phase for four system cycles, with data and frame clock changing only on the bit-clock edge opposite the sampling edge. Each stream is opened by a lead-in at the non-starting frame level and closed by a trailer transition, so every expected word is released.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DW      = 24,
  parameter int IDX_W   = 7,
  parameter int RJ_SPAN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_in,
  input  logic          fclk_in,
  input  logic          sdata_in,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_wlen,
  input  logic [1:0]    pin_fmt,
  output logic [DW-1:0] left_data,
  output logic          left_valid,
  output logic [DW-1:0] right_data,
  output logic          right_valid
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [1:0] F_RJ  = 2'b00;
  localparam logic [1:0] F_I2S = 2'b01;
  localparam logic [1:0] F_DSP = 2'b11;

  logic [2:0] bq;
  logic [1:0] fq, dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bq <= '0;
      fq <= '0;
      dq <= '0;
    end else begin
      bq <= {bq[1:0], bclk_in};
      fq <= {fq[0], fclk_in};
      dq <= {dq[0], sdata_in};
    end
  end

  logic fr, sd, smp_edge;
  logic [1:0] fmt;
  logic is_rj, is_dsp;

  assign fr       = fq[1];
  assign sd       = dq[1];
  assign fmt      = (cfg_fmt != 2'b00) ? cfg_fmt : pin_fmt;
  assign is_rj    = (fmt == F_RJ);
  assign is_dsp   = (fmt == F_DSP);
  assign smp_edge = is_dsp ? (~bq[1] & bq[2]) : (bq[1] & ~bq[2]);

  logic [CW-1:0]    nbits, limit;
  logic [IDX_W-1:0] first;

  always_comb begin
    case (cfg_wlen)
      2'b01:   nbits = CW'(20);
      2'b10:   nbits = CW'(16);
      default: nbits = CW'(DW);
    endcase
    limit = is_rj ? nbits : CW'(DW);
    case (fmt)
      F_RJ:    first = IDX_W'(RJ_SPAN) - IDX_W'(nbits);
      F_I2S:   first = IDX_W'(1);
      default: first = '0;
    endcase
  end

  logic             fr_prev, primed, synced, ch;
  logic [IDX_W-1:0] idx;
  logic [CW-1:0]    n;
  logic [DW-1:0]    sh;

  logic             start, cap, full, flush, ch_c;
  logic [IDX_W-1:0] idx_c;
  logic [CW-1:0]    n_c;
  logic [DW-1:0]    sh_b, sh_c;

  assign start = smp_edge & primed & (is_dsp ? (fr_prev & ~fr) : (fr ^ fr_prev));
  assign idx_c = start ? '0 : idx;
  assign n_c   = start ? '0 : n;
  assign sh_b  = start ? '0 : sh;
  assign sh_c  = {sh_b[DW-2:0], sd};
  assign ch_c  = start ? (is_dsp ? ~ch : (fr ^ (fmt == F_I2S))) : ch;
  assign cap   = smp_edge & (synced | start) & (idx_c >= first) & (n_c < limit);
  assign full  = cap & ((n_c + CW'(1)) == limit);
  assign flush = start & synced & (n != '0) & (n < limit);

  function automatic logic [DW-1:0] shape(input logic [DW-1:0] v, input logic [CW-1:0] cnt,
                                          input logic rj, input logic [CW-1:0] nb);
    logic [DW-1:0] o;
    if (rj) begin
      for (int i = 0; i < DW; i++)
        o[i] = (i < int'(nb)) ? v[i] : v[int'(nb) - 1];
    end else begin
      o = v << (DW - int'(cnt));
    end
    return o;
  endfunction

  logic          emit, emit_left;
  logic [DW-1:0] emit_word;

  assign emit      = flush | full;
  assign emit_left = flush ? ch : ch_c;
  assign emit_word = flush ? shape(sh, n, is_rj, nbits)
                           : shape(sh_c, n_c + CW'(1), is_rj, nbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      fr_prev     <= 1'b0;
      primed      <= 1'b0;
      synced      <= 1'b0;
      ch          <= 1'b0;
      idx         <= '0;
      n           <= '0;
      sh          <= '0;
    end else begin
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      if (emit) begin
        if (emit_left) begin
          left_data  <= emit_word;
          left_valid <= 1'b1;
        end else begin
          right_data  <= emit_word;
          right_valid <= 1'b1;
        end
      end
      if (smp_edge) begin
        fr_prev <= fr;
        primed  <= 1'b1;
        if (start) synced <= 1'b1;
        ch  <= ch_c;
        idx <= (&idx_c) ? idx_c : idx_c + IDX_W'(1);
        n   <= n_c + CW'(cap);
        sh  <= cap ? sh_c : sh_b;
      end
    end
  end

endmodule

module serial_audio_rx_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_fmt,
  input logic [1:0]    cfg_wlen,
  input logic [1:0]    pin_fmt,
  input logic [DW-1:0] left_data,
  input logic          left_valid,
  input logic [DW-1:0] right_data,
  input logic          right_valid
);

  logic rj16;
  assign rj16 = (((cfg_fmt != 2'b00) ? cfg_fmt : pin_fmt) == 2'b00) && (cfg_wlen == 2'b10);

  p_left_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid);

  p_right_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid);

  p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));

  p_left_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_data) |-> left_valid);

  p_right_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_data) |-> right_valid);

  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && rj16) |-> (left_data[DW-1:16] == {(DW-16){left_data[15]}}));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .pin_fmt(pin_fmt),
  .left_data(left_data), .left_valid(left_valid),
  .right_data(right_data), .right_valid(right_valid)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [1:0] cfg_fmt = 2'b00, cfg_wlen = 2'b00, pin_fmt = 2'b00;
  logic [23:0] left_data, right_data;
  logic left_valid, right_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit          exp_ch[$];
  logic [23:0] exp_d[$];
  string       exp_tag[$];

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk), .sdata_in(sdata),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .pin_fmt(pin_fmt),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid)
  );

  task automatic take(input bit ch, input logic [23:0] d);
    checks++;
    if (exp_d.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected %s word act=%h exp=none", ch ? "left" : "right", d);
    end else begin
      bit e_ch = exp_ch.pop_front();
      logic [23:0] e_d = exp_d.pop_front();
      string t = exp_tag.pop_front();
      if (e_ch != ch || e_d !== d) begin
        errors++;
        $display("FAIL %s act=%s:%h exp=%s:%h", t, ch ? "L" : "R", d, e_ch ? "L" : "R", e_d);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (left_valid)  take(1'b1, left_data);
      if (right_valid) take(1'b0, right_data);
    end
  end

  function automatic logic [23:0] exp_val(input int f, input int w, input logic [31:0] word);
    logic [31:0] t;
    if (f == 0) begin
      t = word << (32 - w);
      return 24'($signed(t) >>> (32 - w));
    end
    if (w >= 24) return 24'(word >> (w - 24));
    return 24'(word << (24 - w));
  endfunction

  task automatic send_bit(input bit l, input bit d, input bit dsp);
    @(negedge clk);
    bclk = dsp; fclk = l; sdata = d;
    repeat (4) @(negedge clk);
    bclk = ~dsp;
    repeat (3) @(negedge clk);
  endtask

  task automatic configure(input logic [1:0] rf, input logic [1:0] rw, input logic [1:0] pf, input bit dsp);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fmt = rf; cfg_wlen = rw; pin_fmt = pf;
    bclk = dsp; fclk = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input bit ch, input logic [23:0] d, input string tag);
    exp_ch.push_back(ch); exp_d.push_back(d); exp_tag.push_back(tag);
  endtask

  task automatic lj_half(input bit lvl, input int h, input int s, input int w, input logic [31:0] word);
    for (int i = 0; i < h; i++)
      send_bit(lvl, (i >= s && i < s + w) ? word[w - 1 - (i - s)] : 1'b0, 1'b0);
  endtask

  task automatic dsp_half(input int w, input logic [31:0] word);
    send_bit(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 31; i++)
      send_bit(1'b0, (i < w) ? word[w - 1 - i] : 1'b0, 1'b1);
  endtask

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    checks++;
    if (exp_d.size() != 0) begin
      errors++;
      $display("FAIL %s missing words act=%0d exp=0", tag, exp_d.size());
      exp_ch.delete(); exp_d.delete(); exp_tag.delete();
    end
  endtask

  // f: effective format; s: first data index; h: bits per half
  task automatic stream(input int f, input int w, input int s, input int h,
                        input logic [31:0] lw[], input logic [31:0] rw[], input string tag);
    bit left_lvl = (f != 1);
    bit dsp = (f == 3);
    for (int i = 0; i < 4; i++) send_bit(dsp ? 1'b0 : ~left_lvl, 1'b0, dsp);
    for (int k = 0; k < lw.size(); k++) begin
      push(1'b1, exp_val(f, w, lw[k]), tag);
      push(1'b0, exp_val(f, w, rw[k]), tag);
      if (dsp) begin
        dsp_half(w, lw[k]);
        dsp_half(w, rw[k]);
      end else begin
        lj_half(left_lvl, h, s, w, lw[k]);
        lj_half(~left_lvl, h, s, w, rw[k]);
      end
    end
    if (dsp) begin
      send_bit(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, 1'b1);
    end else begin
      for (int i = 0; i < 4; i++) send_bit(left_lvl, 1'b0, 1'b0);
    end
    drain(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (left_data !== 24'h0 || right_data !== 24'h0 || left_valid !== 1'b0 || right_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset act=%h/%h/%b/%b exp=0/0/0/0", left_data, right_data, left_valid, right_valid);
    end

    // R1 R2: right-justified 24-bit selected by pins
    configure(2'b00, 2'b00, 2'b00, 1'b0);
    stream(0, 24, 8, 32, '{32'h00123456, 32'h00800001}, '{32'h00ABCDEF, 32'h007FFFFE}, "R1 R2 rj24 pins");

    // R3: 20-bit and 16-bit sign extension, code 11 as 24
    configure(2'b00, 2'b01, 2'b00, 1'b0);
    stream(0, 20, 12, 32, '{32'h000F1234, 32'h00080000}, '{32'h00054321, 32'h0007FFFF}, "R3 rj20");
    configure(2'b00, 2'b10, 2'b00, 1'b0);
    stream(0, 16, 16, 32, '{32'h00008001, 32'h00001234}, '{32'h0000FFFF, 32'h00007ABC}, "R3 rj16");
    configure(2'b00, 2'b11, 2'b00, 1'b0);
    stream(0, 24, 8, 32, '{32'h00F00F0F}, '{32'h000F0F0F}, "R3 rj code11");

    // R10: longer halves keep the same offset
    configure(2'b00, 2'b00, 2'b00, 1'b0);
    stream(0, 24, 8, 48, '{32'h00A5A5A5}, '{32'h005A5A5A}, "R10 rj48");

    // R1 R4: I2S from register, pins ignored
    configure(2'b01, 2'b00, 2'b11, 1'b0);
    stream(1, 24, 1, 32, '{32'h00C0FFEE, 32'h00000001}, '{32'h00123ABC, 32'h00FFFFFF}, "R1 R4 i2s");

    // R5 R8: left-justified from pins, 16-bit words
    configure(2'b00, 2'b00, 2'b10, 1'b0);
    stream(2, 16, 0, 32, '{32'h0000BEEF}, '{32'h00001357}, "R5 R8 lj16");
    // R5 R7: 32-bit words truncated
    configure(2'b00, 2'b00, 2'b10, 1'b0);
    stream(2, 32, 0, 32, '{32'h89ABCDEF}, '{32'h13579BDF}, "R5 R7 lj32");
    // R5: 24-bit words, cfg_wlen has no effect outside right-justified
    configure(2'b10, 2'b10, 2'b00, 1'b0);
    stream(2, 24, 0, 32, '{32'h00654321}, '{32'h00FEDCBA}, "R5 R1 lj24");

    // R6: DSP mode 24-bit and 20-bit
    configure(2'b11, 2'b00, 2'b00, 1'b0);
    stream(3, 24, 0, 32, '{32'h00DEAD01, 32'h00700007}, '{32'h00BEEF02, 32'h00012345}, "R6 dsp24");
    configure(2'b00, 2'b00, 2'b11, 1'b0);
    stream(3, 20, 0, 32, '{32'h000ABCDE}, '{32'h00054321}, "R6 R8 dsp20");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule